// File: doc/BRIEF.md
# Multichannel Demand-Pulled Clock-Crossing FIFO

This block carries multichannel transmit samples from a source domain (a DMA engine or sample unpacker) into a device domain (a converter interface core) that runs on its own clock. The device side decides when it takes a sample: it strobes a per-channel valid and gets back, one device clock later, the data and a registered copy of that strobe. On the source side the FIFO asks for data itself, raising a request strobe on every channel while it has room for at least one more storage word. The source answers in the same cycle with its data and a looped-back valid per channel.

Each storage word is as wide as the wider of the two per-channel lane widths. When the source lane is narrower, several source beats are packed into one word. When the device lane is narrower, one word is handed out as several device beats. In both cases the lowest slice of a word holds the earliest sample. The ratio of the two widths must be 1, 2, 4 or 8, and at most 8 channels are allowed; other settings stop elaboration. Write and read pointers cross the boundary as gray codes through two-flop synchronizers. An underflow flag from the source is synchronized and shown on the device side, combined with the device-side underflow raised when a pull finds the FIFO empty.

Top module: `xclk_pull_fifo`

## Requirements
- R1: With default widths (32-bit source lanes, 64-bit device lanes) one storage word holds two source beats, so the bench can predict exactly how many beats it takes to fill the FIFO.
- R2: All bits of `srcValid` are equal. They are high whenever fewer than 2^ADDR_W words are stored, and low when the FIFO is full. With the defaults, an empty FIFO accepts exactly 512 beats before the request drops.
- R3: A beat offered on `srcValidIn` while `srcValid` is low is discarded and never reaches the device side.
- R4: Within a word, slice 0 (bits [SRC_W-1:0] of the lane) holds the earliest source beat, and slices fill in ascending order. A word that is only partly packed is not visible to the device side.
- R5: In an accepted beat, a channel whose `srcValidIn` bit is low stores zero in its slice. The other channels store their data.
- R6: One device clock after a pull (`devValid` not zero), `devData` carries the next word slice for every lane, and `devValidOut` equals the `devValid` of the previous cycle.
- R7: A pull while the FIFO is empty makes `devData` zero and raises `devUnf` in the next cycle. Without a further empty pull and with `srcUnf` low, `devUnf` is low again one cycle later.
- R8: `srcUnf` high appears on `devUnf` within three device clocks, and its release also clears `devUnf` within three device clocks.
- R9: `srcEnable` follows `devEnable` through a two-flop synchronizer in the source clock.
- R10: While in reset, `srcValid`, `srcEnable`, `devData`, `devValidOut` and `devUnf` are all zero. Each reset clears only its own domain.
- R11: The gray write pointer changes in at most one bit per source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source-domain clock |
| srcRstN | input | 1 | Source-domain reset, active low, asynchronous |
| srcUnf | input | 1 | Underflow flag from the source |
| srcEnable | output | NUM_CH | Channel enables, synchronized to the source clock |
| srcValid | output | NUM_CH | Request strobe per channel |
| srcValidIn | input | NUM_CH | Looped-back valid per channel, same cycle as the request |
| srcData | input | NUM_CH*SRC_W | Source sample lanes, channel 0 in the lowest bits |
| devClk | input | 1 | Device-domain clock |
| devRst | input | 1 | Device-domain reset, active high, asynchronous |
| devEnable | input | NUM_CH | Channel enables from the device |
| devValid | input | NUM_CH | Pull strobe per channel |
| devValidOut | output | NUM_CH | Registered copy of the pull strobe |
| devData | output | NUM_CH*DEV_W | Device sample lanes, channel 0 in the lowest bits |
| devUnf | output | 1 | Underflow, device domain |

## Verification
The bound checker watches, on every cycle, the properties that are local in time. No word is written while the request is low, the request lanes always agree, the gray write pointer steps by at most one bit, an empty pull produces zero data with underflow, and the valid loopback trails the pull by one cycle. What only the bench scenarios can show depends on history across both clocks. These are the exact fill count, the slice order within each packed word, zero lanes from masked looped-back valids, the discard of beats offered while full, the hiding of a half-packed word, and the latency of the enable and underflow crossings.

// File: rtl/xclk_pull_fifo_pkg.sv
`timescale 1ns/1ps
package xclk_pull_fifo_pkg;

  // Source-domain strobes from control to datapath
  typedef struct packed {
    logic       accept;   // a beat is taken this cycle
    logic       wrEn;     // the packed word is committed to storage
    logic [2:0] packIdx;  // slice the current beat lands in
  } srcStrobe_t;

  // Device-domain strobes from control to datapath
  typedef struct packed {
    logic       pull;     // any lane pulls this cycle
    logic       underrun; // pull while nothing is stored
    logic [2:0] sliceIdx; // slice of the head word handed out
  } devStrobe_t;

endpackage

// File: rtl/xclk_pull_fifo_sync.sv
`timescale 1ns/1ps
module xclk_pull_fifo_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/xclk_pull_fifo_ctrl.sv
`timescale 1ns/1ps
module xclk_pull_fifo_ctrl
  import xclk_pull_fifo_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SRC_SLICES = 2,
  parameter int DEV_SLICES = 1
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic              anyValidIn,
  output logic              srcReq,
  output srcStrobe_t        srcS,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W:0]   wrGray,
  input  logic              devClk,
  input  logic              devRst,
  input  logic              anyPull,
  output devStrobe_t        devS,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              empty
);

  localparam int PW = ADDR_W + 1;
  localparam logic [2:0] SRC_LAST = 3'(SRC_SLICES - 1);
  localparam logic [2:0] DEV_LAST = 3'(DEV_SLICES - 1);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // ---------------- source domain ----------------
  logic          srcClr;
  logic          srcUp;
  logic [PW-1:0] wBin;
  logic [PW-1:0] rGraySync;
  logic [2:0]    packCnt;
  logic          full;
  logic          lastBeat;

  assign srcClr   = ~srcRstN;
  assign full     = (wrGray == {~rGraySync[PW-1:PW-2], rGraySync[PW-3:0]});
  assign srcReq   = srcUp & ~full;
  assign lastBeat = (packCnt == SRC_LAST);

  assign srcS.accept  = srcReq & anyValidIn;
  assign srcS.wrEn    = srcS.accept & lastBeat;
  assign srcS.packIdx = packCnt;
  assign wrAddr       = wBin[ADDR_W-1:0];

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN) begin
      srcUp   <= 1'b0;
      wBin    <= '0;
      wrGray  <= '0;
      packCnt <= '0;
    end else begin
      srcUp <= 1'b1;
      if (srcS.accept) packCnt <= lastBeat ? 3'd0 : packCnt + 3'd1;
      if (srcS.wrEn) begin
        wBin   <= wBin + PW'(1);
        wrGray <= toGray(wBin + PW'(1));
      end
    end
  end

  // ---------------- device domain ----------------
  logic [PW-1:0] rBin;
  logic [PW-1:0] rGray;
  logic [PW-1:0] wGraySync;
  logic [2:0]    sliceCnt;
  logic          lastSlice;

  assign empty     = (rGray == wGraySync);
  assign lastSlice = (sliceCnt == DEV_LAST);

  assign devS.pull     = anyPull;
  assign devS.underrun = anyPull & empty;
  assign devS.sliceIdx = sliceCnt;
  assign rdAddr        = rBin[ADDR_W-1:0];

  always_ff @(posedge devClk or posedge devRst) begin
    if (devRst) begin
      rBin     <= '0;
      rGray    <= '0;
      sliceCnt <= '0;
    end else if (anyPull && !empty) begin
      sliceCnt <= lastSlice ? 3'd0 : sliceCnt + 3'd1;
      if (lastSlice) begin
        rBin  <= rBin + PW'(1);
        rGray <= toGray(rBin + PW'(1));
      end
    end
  end

  // ---------------- pointer crossings ----------------
  xclk_pull_fifo_sync #(.W(PW)) u_wSync (
    .clk(devClk), .clr(devRst), .d(wrGray), .q(wGraySync)
  );

  xclk_pull_fifo_sync #(.W(PW)) u_rSync (
    .clk(srcClk), .clr(srcClr), .d(rGray), .q(rGraySync)
  );

endmodule

// File: rtl/xclk_pull_fifo_dpath.sv
`timescale 1ns/1ps
module xclk_pull_fifo_dpath
  import xclk_pull_fifo_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SRC_W  = 32,
  parameter int DEV_W  = 64,
  parameter int WORD_W = 64,
  parameter int ADDR_W = 8
) (
  input  logic                    srcClk,
  input  logic                    srcRstN,
  input  srcStrobe_t              srcS,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [NUM_CH-1:0]       srcValidIn,
  input  logic [NUM_CH*SRC_W-1:0] srcData,
  input  logic                    devClk,
  input  logic                    devRst,
  input  devStrobe_t              devS,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic                    unfSync,
  input  logic [NUM_CH-1:0]       devValid,
  output logic [NUM_CH-1:0]       devValidOut,
  output logic [NUM_CH*DEV_W-1:0] devData,
  output logic                    devUnf
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int MEM_W = NUM_CH * WORD_W;

  logic [MEM_W-1:0] mem [DEPTH];
  logic [MEM_W-1:0] memIn;
  logic [MEM_W-1:0] headWord;

  assign headWord = mem[rdAddr];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    logic [SRC_W-1:0]  laneIn;
    logic [WORD_W-1:0] packReg;
    logic [WORD_W-1:0] wordIn;
    logic [DEV_W-1:0]  laneOut;

    // R5: a lane without its looped-back valid contributes zero
    assign laneIn = srcValidIn[ch] ? srcData[ch*SRC_W +: SRC_W] : '0;

    // R4: beat k lands in slice k, slice 0 at the low end
    always_comb begin
      wordIn = packReg;
      wordIn[srcS.packIdx*SRC_W +: SRC_W] = laneIn;
    end

    always_ff @(posedge srcClk or negedge srcRstN) begin
      if (!srcRstN) packReg <= '0;
      else if (srcS.accept) packReg <= wordIn;
    end

    assign memIn[ch*WORD_W +: WORD_W] = wordIn;
    assign laneOut = headWord[ch*WORD_W + devS.sliceIdx*DEV_W +: DEV_W];

    always_ff @(posedge devClk or posedge devRst) begin
      if (devRst) devData[ch*DEV_W +: DEV_W] <= '0;
      else if (devS.pull) devData[ch*DEV_W +: DEV_W] <= devS.underrun ? '0 : laneOut;
    end
  end

  always_ff @(posedge srcClk) begin
    if (srcS.wrEn) mem[wrAddr] <= memIn;
  end

  always_ff @(posedge devClk or posedge devRst) begin
    if (devRst) begin
      devValidOut <= '0;
      devUnf      <= 1'b0;
    end else begin
      devValidOut <= devValid;
      devUnf      <= devS.underrun | unfSync;
    end
  end

endmodule

// File: rtl/xclk_pull_fifo.sv
`timescale 1ns/1ps
module xclk_pull_fifo
  import xclk_pull_fifo_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SRC_W  = 32,
  parameter int DEV_W  = 64,
  parameter int ADDR_W = 8
) (
  input  logic                    srcClk,
  input  logic                    srcRstN,
  input  logic                    srcUnf,
  output logic [NUM_CH-1:0]       srcEnable,
  output logic [NUM_CH-1:0]       srcValid,
  input  logic [NUM_CH-1:0]       srcValidIn,
  input  logic [NUM_CH*SRC_W-1:0] srcData,
  input  logic                    devClk,
  input  logic                    devRst,
  input  logic [NUM_CH-1:0]       devEnable,
  input  logic [NUM_CH-1:0]       devValid,
  output logic [NUM_CH-1:0]       devValidOut,
  output logic [NUM_CH*DEV_W-1:0] devData,
  output logic                    devUnf
);

  localparam int WORD_W     = (SRC_W > DEV_W) ? SRC_W : DEV_W;
  localparam int NARROW_W   = (SRC_W > DEV_W) ? DEV_W : SRC_W;
  localparam int RATIO      = WORD_W / NARROW_W;
  localparam int SRC_SLICES = WORD_W / SRC_W;
  localparam int DEV_SLICES = WORD_W / DEV_W;

  // Elaboration guards: width ratio 1/2/4/8, 1..8 channels, depth >= 4
  if ((WORD_W % NARROW_W != 0) ||
      !(RATIO == 1 || RATIO == 2 || RATIO == 4 || RATIO == 8)) begin : g_badRatio
    $error("xclk_pull_fifo: lane width ratio must be 1, 2, 4 or 8");
  end
  if (NUM_CH < 1 || NUM_CH > 8) begin : g_badCh
    $error("xclk_pull_fifo: channel count must be 1 to 8");
  end
  if (ADDR_W < 2) begin : g_badAddr
    $error("xclk_pull_fifo: address width must be at least 2");
  end

  srcStrobe_t        srcS;
  devStrobe_t        devS;
  logic              srcReq;
  logic              srcClr;
  logic              empty;
  logic              unfSync;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W:0]   wrGray;

  assign srcClr   = ~srcRstN;
  assign srcValid = {NUM_CH{srcReq}};  // R2

  xclk_pull_fifo_ctrl #(
    .ADDR_W(ADDR_W), .SRC_SLICES(SRC_SLICES), .DEV_SLICES(DEV_SLICES)
  ) u_ctrl (
    .srcClk(srcClk), .srcRstN(srcRstN), .anyValidIn(|srcValidIn),
    .srcReq(srcReq), .srcS(srcS), .wrAddr(wrAddr), .wrGray(wrGray),
    .devClk(devClk), .devRst(devRst), .anyPull(|devValid),
    .devS(devS), .rdAddr(rdAddr), .empty(empty)
  );

  xclk_pull_fifo_dpath #(
    .NUM_CH(NUM_CH), .SRC_W(SRC_W), .DEV_W(DEV_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
  ) u_dpath (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcS(srcS), .wrAddr(wrAddr),
    .srcValidIn(srcValidIn), .srcData(srcData),
    .devClk(devClk), .devRst(devRst), .devS(devS), .rdAddr(rdAddr),
    .unfSync(unfSync), .devValid(devValid), .devValidOut(devValidOut),
    .devData(devData), .devUnf(devUnf)
  );

  // R9: enables into the source clock
  xclk_pull_fifo_sync #(.W(NUM_CH)) u_enSync (
    .clk(srcClk), .clr(srcClr), .d(devEnable), .q(srcEnable)
  );

  // R8: source underflow into the device clock
  xclk_pull_fifo_sync #(.W(1)) u_unfSync (
    .clk(devClk), .clr(devRst), .d(srcUnf), .q(unfSync)
  );

endmodule

// File: rtl/xclk_pull_fifo_chk.sv
`timescale 1ns/1ps
module xclk_pull_fifo_chk
  import xclk_pull_fifo_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DEV_W  = 64,
  parameter int ADDR_W = 8
) (
  input logic                    srcClk,
  input logic                    srcRstN,
  input logic                    devClk,
  input logic                    devRst,
  input logic [NUM_CH-1:0]       srcValid,
  input srcStrobe_t              srcS,
  input logic [ADDR_W:0]         wrGray,
  input devStrobe_t              devS,
  input logic [NUM_CH-1:0]       devValid,
  input logic [NUM_CH-1:0]       devValidOut,
  input logic [NUM_CH*DEV_W-1:0] devData,
  input logic                    devUnf
);

  AST_NO_OVERFLOW: assert property (@(posedge srcClk) disable iff (!srcRstN)
    srcS.wrEn |-> srcValid[0]);  // R3

  AST_REQ_UNIFORM: assert property (@(posedge srcClk) disable iff (!srcRstN)
    (srcValid == '0) || (&srcValid));  // R2

  AST_GRAY_STEP: assert property (@(posedge srcClk) disable iff (!srcRstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);  // R11

  AST_UNDERRUN_ZERO: assert property (@(posedge devClk) disable iff (devRst)
    devS.underrun |=> (devData == '0) && devUnf);  // R7

  AST_VALID_LOOP: assert property (@(posedge devClk) disable iff (devRst)
    1'b1 |=> devValidOut == $past(devValid));  // R6

endmodule

bind xclk_pull_fifo xclk_pull_fifo_chk #(
  .NUM_CH(NUM_CH), .DEV_W(DEV_W), .ADDR_W(ADDR_W)
) u_chk (
  .srcClk(srcClk), .srcRstN(srcRstN), .devClk(devClk), .devRst(devRst),
  .srcValid(srcValid), .srcS(srcS), .wrGray(wrGray), .devS(devS),
  .devValid(devValid), .devValidOut(devValidOut), .devData(devData),
  .devUnf(devUnf)
);

// File: tb/sim_xclk_pull_fifo.sv
`timescale 1ns/1ps
module sim_xclk_pull_fifo;

  localparam int NCH = 4;
  localparam int SW  = 32;
  localparam int DW  = 64;
  localparam int AW  = 8;

  logic            srcClk = 0, devClk = 0;
  logic            srcRstN = 0, devRst = 1;
  logic            srcUnf = 0;
  logic [NCH-1:0]  srcEnable, srcValid, srcValidIn = '0;
  logic [NCH*SW-1:0] srcData = '0;
  logic [NCH-1:0]  devEnable = '0, devValid = '0, devValidOut;
  logic [NCH*DW-1:0] devData;
  logic            devUnf;

  int errors = 0, checks = 0;
  bit done = 0;

  always #20 srcClk = ~srcClk;  // slower source side
  always #10 devClk = ~devClk;  // 50 MHz device side

  xclk_pull_fifo #(.NUM_CH(NCH), .SRC_W(SW), .DEV_W(DW), .ADDR_W(AW)) u0 (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcUnf(srcUnf), .srcEnable(srcEnable),
    .srcValid(srcValid), .srcValidIn(srcValidIn), .srcData(srcData),
    .devClk(devClk), .devRst(devRst), .devEnable(devEnable), .devValid(devValid),
    .devValidOut(devValidOut), .devData(devData), .devUnf(devUnf)
  );

  // stimulus {devEnable, expected srcEnable}
  localparam logic [7:0] EN_VEC [5] = '{8'h00, 8'hAA, 8'h77, 8'h11, 8'hFF};

  function automatic logic [SW-1:0] samp(input int ch, input int k);
    return {4'hA, 4'(ch), 24'(k)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic putBeat(input logic [NCH-1:0] mask, input int k);
    @(negedge srcClk);
    srcValidIn = mask;
    for (int ch = 0; ch < NCH; ch++) srcData[ch*SW +: SW] = samp(ch, k);
    @(posedge srcClk);
    #1 srcValidIn = '0;
  endtask

  task automatic pull(input logic [NCH-1:0] mask);
    devValid = mask;
    @(negedge devClk);
    devValid = '0;
  endtask

  function automatic logic [NCH*DW-1:0] pair(input logic [NCH-1:0] mask, input int k);
    logic [NCH*DW-1:0] w;
    for (int ch = 0; ch < NCH; ch++)
      w[ch*DW +: DW] = mask[ch] ? {samp(ch, k + 1), samp(ch, k)} : '0;
    return w;
  endfunction

  initial begin
    #3000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int k;
    // ---- reset state (R10) ----
    #55;
    chk(srcValid == '0 && srcEnable == '0, "R10 src in reset", {srcValid, srcEnable}, 0);
    chk(devData == '0 && devValidOut == '0 && devUnf == 0, "R10 dev in reset",
        {devData[NCH*DW-1:8], devValidOut, 3'b0, devUnf}, 0);
    #50 devRst = 0;
    #80 srcRstN = 1;
    repeat (4) @(negedge srcClk);
    chk(srcValid == '1, "R2 request after reset", srcValid, '1);

    // ---- enable crossing vectors (R9) ----
    for (int i = 0; i < 5; i++) begin
      @(negedge devClk) devEnable = EN_VEC[i][7:4];
      repeat (3) @(negedge srcClk);
      chk(srcEnable == EN_VEC[i][3:0], "R9 enable sync", srcEnable, EN_VEC[i][3:0]);
    end

    // ---- fill until request drops (R1, R2) ----
    k = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge srcClk);
      if (srcValid != '1) break;
      srcValidIn = '1;
      for (int ch = 0; ch < NCH; ch++) srcData[ch*SW +: SW] = samp(ch, k);
      @(posedge srcClk);
      k++;
    end
    chk(k == 512, "R1 R2 beats to fill", k, 512);
    chk(srcValid == '0, "R2 request low when full", srcValid, 0);
    // offer junk while request is low (R3)
    srcData = {NCH{32'hDEADBEEF}};
    srcValidIn = '1;
    repeat (6) @(negedge srcClk);
    srcValidIn = '0;

    // ---- drain and compare (R4, R6) ----
    @(negedge devClk);
    for (int j = 0; j < 256; j++) begin
      pull('1);
      chk(devData == pair('1, 2 * j), "R4 word order", devData, pair('1, 2 * j));
      chk(devValidOut == '1 && devUnf == 0, "R6 valid loopback", {devValidOut, devUnf}, 5'b11110);
    end

    // ---- underflow on empty (R3, R7) ----
    pull(4'b0110);
    chk(devData == '0 && devUnf == 1, "R3 R7 empty pull", {devData[NCH*DW-1:1], devUnf}, 1);
    chk(devValidOut == 4'b0110, "R6 partial valid loopback", devValidOut, 4'b0110);
    @(negedge devClk);
    chk(devUnf == 0 && devValidOut == '0, "R7 underflow one cycle", {devValidOut, devUnf}, 0);

    repeat (6) @(negedge srcClk);
    chk(srcValid == '1, "R2 request after drain", srcValid, '1);

    // ---- lane masking (R5) ----
    putBeat(4'b0101, 600);
    putBeat(4'b0101, 601);
    repeat (8) @(negedge devClk);
    pull('1);
    chk(devData == pair(4'b0101, 600), "R5 masked lanes", devData, pair(4'b0101, 600));

    // ---- partial word hidden (R4) ----
    putBeat('1, 700);
    putBeat('1, 701);
    putBeat('1, 702);
    repeat (8) @(negedge devClk);
    pull('1);
    chk(devData == pair('1, 700), "R4 packed pair", devData, pair('1, 700));
    pull('1);
    chk(devUnf == 1 && devData == '0, "R4 partial not visible", {devData[NCH*DW-1:1], devUnf}, 1);
    putBeat('1, 703);
    repeat (8) @(negedge devClk);
    pull('1);
    chk(devData == pair('1, 702), "R4 completed pair", devData, pair('1, 702));

    // ---- source underflow crossing (R8) ----
    @(negedge srcClk) srcUnf = 1;
    repeat (4) @(negedge devClk);
    chk(devUnf == 1, "R8 underflow forwarded", devUnf, 1);
    @(negedge srcClk) srcUnf = 0;
    repeat (4) @(negedge devClk);
    chk(devUnf == 0, "R8 underflow released", devUnf, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule